// File: doc/BRIEF.md
# Latched Chip Reset Controller

This block holds a chip in reset until software lets it go. The reset starts from either an active-low hardware reset pin or a host write to the reset control register at byte offset 0000h. Once started, the reset stays latched in a status bit. That bit drives the module reset output, so every downstream block stays in reset for as long as the bit is set.

While the bit is set, the host can reach only the reset control register. The block discards writes to any other address and returns zero for reads from them. When the pin is released, its synchronized copy starts a timer that measures the required settling interval. The host polls a ready flag in the control register. The host then clears the reset bit, and a clear that arrives before the ready flag is set has no effect. A software set restarts the interval.

Top module: `latched_reset_ctrl`

## Requirements
- R1: Driving `rst_pin_n` low sets the reset bit and `mod_rst` at once, without waiting for a clock edge. It also clears the ready flag, so the control register reads 0001h.
- R2: The pin release passes through SYNC_STAGES synchronizer flops. After that the timer counts one step per clock. The ready flag (control register bit 15) reads 1 once SYNC_STAGES+CLEAR_WAIT rising edges have passed since the release, and it stays 1 until the timer is restarted.
- R3: A host write to the control register with data bit 0 = 1 sets the reset bit on that clock edge and restarts the timer. The ready flag then reads 0, and it returns CLEAR_WAIT edges after the write. This holds even when the bit is already set.
- R4: A host write to the control register with data bit 0 = 0 while the ready flag is 0 is ignored, and the reset bit stays 1.
- R5: A host write to the control register with data bit 0 = 0 while the ready flag is 1 clears the reset bit on that edge.
- R6: While the reset bit is 1, an access to any address other than the control register does not reach downstream: `down_wr_en` and `down_rd_en` stay 0 and `host_rdata` is 0000h.
- R7: While the reset bit is 0, an access to any other address passes through: `down_wr_en` equals `host_wr`, `down_rd_en` equals `host_rd`, and `host_rdata` equals `down_rdata`.
- R8: The control register is selected by every byte address whose upper bits equal CTRL_ADDR, with address bit 0 ignored. It reads bit 0 = reset bit, bit 15 = ready and all other bits 0, and an access to it never raises a downstream strobe.
- R9: `mod_rst` equals the reset bit at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_pin_n | input | 1 | Active-low hardware reset pin, asynchronous |
| host_addr | input | ADDR_W | Host byte address |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data |
| down_rdata | input | DATA_W | Read data from the downstream registers |
| down_wr_en | output | 1 | Gated write strobe to the downstream registers |
| down_rd_en | output | 1 | Gated read strobe to the downstream registers |
| mod_rst | output | 1 | Active-high module reset to downstream logic |

## Verification
The hardest cases to reach are clear attempts that land on the exact edges around the end of the settling window, both after a pin release and after a software set. Getting there means counting every synchronizer stage and every timer step. The bench sweeps the clear write across every edge offset, from the release itself to a few edges past ready, on a small configuration. Each offset starts from a fresh reset. The bench computes arithmetically whether each clear takes effect, then checks the outcome at the ports.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
   localparam int READY_BIT = 15;
   localparam int LATCH_BIT = 0;

   function automatic logic [15:0] make_ctrl(input logic ready, input logic latched);
      logic [15:0] w;
      w            = '0;
      w[READY_BIT] = ready;
      w[LATCH_BIT] = latched;
      return w;
   endfunction
endpackage

// File: rtl/rstc_sync.sv
module rstc_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   output logic sync_n
);
   if (STAGES < 2) begin : g_bad_stages
      $error("rstc_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) chain <= '0;
      else         chain <= {chain[STAGES-2:0], 1'b1};
   end

   assign sync_n = chain[STAGES-1];
endmodule

// File: rtl/rstc_timer.sv
module rstc_timer #(
   parameter int WAIT = 400
) (
   input  logic clk,
   input  logic arst_n,
   input  logic restart,
   output logic ready
);
   if (WAIT < 1) begin : g_bad_wait
      $error("rstc_timer: WAIT must be at least 1");
   end

   localparam int CNT_W = $clog2(WAIT + 1);
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(WAIT);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)            cnt <= '0;
      else if (restart)       cnt <= '0;
      else if (cnt != LIMIT)  cnt <= cnt + 1'b1;
   end

   assign ready = (cnt == LIMIT);
endmodule

// File: rtl/rstc_gate.sv
module rstc_gate #(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 16,
   parameter int CTRL_ADDR = 0
) (
   input  logic [ADDR_W-1:0] host_addr,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic              locked,
   input  logic [DATA_W-1:0] ctrl_word,
   input  logic [DATA_W-1:0] down_rdata,
   output logic [DATA_W-1:0] host_rdata,
   output logic              down_wr_en,
   output logic              down_rd_en,
   output logic              ctrl_wr
);
   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

   logic is_ctrl;
   logic addr_lsb_unused;

   assign addr_lsb_unused = host_addr[0];
   assign is_ctrl    = (host_addr[ADDR_W-1:1] == CTRL_A[ADDR_W-1:1]);
   assign ctrl_wr    = host_wr & is_ctrl;
   assign down_wr_en = host_wr & ~is_ctrl & ~locked;
   assign down_rd_en = host_rd & ~is_ctrl & ~locked;

   always_comb begin
      if (is_ctrl)     host_rdata = ctrl_word;
      else if (locked) host_rdata = '0;
      else             host_rdata = down_rdata;
   end
endmodule

// File: rtl/latched_reset_ctrl.sv
module latched_reset_ctrl #(
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 16,
   parameter int CTRL_ADDR   = 0,
   parameter int SYNC_STAGES = 2,
   parameter int CLEAR_WAIT  = 400
) (
   input  logic              clk,
   input  logic              rst_pin_n,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   input  logic [DATA_W-1:0] down_rdata,
   output logic              down_wr_en,
   output logic              down_rd_en,
   output logic              mod_rst
);
   import rstc_pkg::*;

   if (DATA_W < 16) begin : g_bad_data
      $error("latched_reset_ctrl: DATA_W must be at least 16");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("latched_reset_ctrl: ADDR_W must be at least 2");
   end

   logic              sync_n;
   logic              ready_w;
   logic              ctrl_wr;
   logic              sw_set;
   logic              latch_q;
   logic [DATA_W-1:0] ctrl_word;
   logic              wdata_unused;

   assign wdata_unused = ^host_wdata[DATA_W-1:1];

   rstc_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk    (clk),
      .arst_n (rst_pin_n),
      .sync_n (sync_n)
   );

   assign sw_set = ctrl_wr & host_wdata[0];

   rstc_timer #(.WAIT(CLEAR_WAIT)) timer_i (
      .clk     (clk),
      .arst_n  (sync_n),
      .restart (sw_set),
      .ready   (ready_w)
   );

   always_ff @(posedge clk or negedge sync_n) begin
      if (!sync_n)                 latch_q <= 1'b1;
      else if (sw_set)             latch_q <= 1'b1;
      else if (ctrl_wr && ready_w) latch_q <= 1'b0;
   end

   always_comb begin
      ctrl_word        = '0;
      ctrl_word[15:0]  = make_ctrl(ready_w, latch_q);
   end

   rstc_gate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR)) gate_i (
      .host_addr  (host_addr),
      .host_wr    (host_wr),
      .host_rd    (host_rd),
      .locked     (latch_q),
      .ctrl_word  (ctrl_word),
      .down_rdata (down_rdata),
      .host_rdata (host_rdata),
      .down_wr_en (down_wr_en),
      .down_rd_en (down_rd_en),
      .ctrl_wr    (ctrl_wr)
   );

   assign mod_rst = latch_q;
endmodule

// File: rtl/rstc_chk.sv
module rstc_chk #(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 16,
   parameter int CTRL_ADDR = 0
) (
   input logic              clk,
   input logic              rst_pin_n,
   input logic [ADDR_W-1:0] host_addr,
   input logic              host_wr,
   input logic              host_rd,
   input logic [DATA_W-1:0] host_wdata,
   input logic [DATA_W-1:0] host_rdata,
   input logic [DATA_W-1:0] down_rdata,
   input logic              down_wr_en,
   input logic              down_rd_en,
   input logic              mod_rst,
   input logic              ready
);
   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

   logic is_ctrl;
   assign is_ctrl = (host_addr[ADDR_W-1:1] == CTRL_A[ADDR_W-1:1]);

   AST_BLOCK_STROBES: assert property (@(posedge clk) disable iff (!rst_pin_n)
      mod_rst |-> (!down_wr_en && !down_rd_en));                                  // R6
   AST_BLOCK_RDATA: assert property (@(posedge clk) disable iff (!rst_pin_n)
      (mod_rst && !is_ctrl) |-> (host_rdata == '0));                              // R6
   AST_PASS_OPEN: assert property (@(posedge clk) disable iff (!rst_pin_n)
      (!mod_rst && !is_ctrl) |-> (down_wr_en == host_wr && down_rd_en == host_rd
                                  && host_rdata == down_rdata));                  // R7
   AST_CTRL_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_pin_n)
      is_ctrl |-> (!down_wr_en && !down_rd_en));                                  // R8
   AST_CTRL_READ: assert property (@(posedge clk) disable iff (!rst_pin_n)
      is_ctrl |-> (host_rdata[0] == mod_rst && host_rdata[15] == ready));         // R9
   AST_SET_WRITE: assert property (@(posedge clk) disable iff (!rst_pin_n)
      (host_wr && is_ctrl && host_wdata[0]) |=> (mod_rst && !ready));             // R3
   AST_EARLY_CLEAR: assert property (@(posedge clk) disable iff (!rst_pin_n)
      (host_wr && is_ctrl && !host_wdata[0] && !ready && mod_rst) |=> mod_rst);   // R4
   AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_pin_n)
      (host_wr && is_ctrl && !host_wdata[0] && ready) |=> !mod_rst);              // R5
   AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_pin_n)
      (ready && !(host_wr && is_ctrl && host_wdata[0])) |=> ready);               // R2
endmodule

bind latched_reset_ctrl rstc_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR)
) chk_i (
   .clk        (clk),
   .rst_pin_n  (rst_pin_n),
   .host_addr  (host_addr),
   .host_wr    (host_wr),
   .host_rd    (host_rd),
   .host_wdata (host_wdata),
   .host_rdata (host_rdata),
   .down_rdata (down_rdata),
   .down_wr_en (down_wr_en),
   .down_rd_en (down_rd_en),
   .mod_rst    (mod_rst),
   .ready      (ready_w)
);

// File: tb/latched_reset_ctrl_tb_top.sv
`timescale 1ns/1ps
module latched_reset_ctrl_tb_top;
   localparam int AW = 8;
   localparam int DW = 16;
   localparam int SS = 2;
   localparam int W  = 6;

   logic          clk = 1'b0;
   logic          rst_pin_n;
   logic [AW-1:0] host_addr;
   logic          host_wr;
   logic          host_rd;
   logic [DW-1:0] host_wdata;
   logic [DW-1:0] host_rdata;
   logic [DW-1:0] down_rdata;
   logic          down_wr_en;
   logic          down_rd_en;
   logic          mod_rst;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   latched_reset_ctrl #(
      .ADDR_W(AW), .DATA_W(DW), .CTRL_ADDR(0), .SYNC_STAGES(SS), .CLEAR_WAIT(W)
   ) dut_i (
      .clk(clk), .rst_pin_n(rst_pin_n), .host_addr(host_addr), .host_wr(host_wr),
      .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .down_rdata(down_rdata), .down_wr_en(down_wr_en), .down_rd_en(down_rd_en),
      .mod_rst(mod_rst)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] ctrl_exp(input bit rdy, input bit lat);
      return {rdy, 14'b0, lat};
   endfunction

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      host_addr  = a;
      host_wdata = d;
      host_wr    = 1'b1;
      tick();
      host_wr    = 1'b0;
   endtask

   task automatic rd_ctrl(output logic [DW-1:0] v);
      host_addr = '0;
      #0.2;
      v = host_rdata;
   endtask

   task automatic hw_reset();
      rst_pin_n = 1'b0;
      tick();
      rst_pin_n = 1'b1;
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL R2 watchdog expired act=0 exp=1");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] v;
      rst_pin_n  = 1'b0;
      host_addr  = '0;
      host_wr    = 1'b0;
      host_rd    = 1'b0;
      host_wdata = '0;
      down_rdata = 16'hA5C3;
      tick(); tick(); tick();

      // R1, R9: reset state
      rd_ctrl(v);
      chk("R1 reset ctrl word", v, ctrl_exp(0, 1));
      chk("R9 mod_rst in reset", mod_rst, 1);
      rst_pin_n = 1'b1;

      // R2 R4 R5: clear attempt after hardware release, swept over edge offsets
      for (int k = 0; k <= W + SS + 2; k++) begin
         bit ok;
         hw_reset();
         repeat (k) tick();
         ok = (k >= W + SS);
         rd_ctrl(v);
         chk(ok ? "R2 ready after release" : "R2 not ready after release", v, ctrl_exp(ok, 1));
         wr(0, 16'h0000);
         chk(ok ? "R5 clear when ready" : "R4 early clear ignored", mod_rst, !ok);
      end

      // R3 R4 R5: software set, then clear swept over offsets
      for (int j = 0; j <= W + 2; j++) begin
         bit ok;
         wr(0, 16'h0001);
         chk("R3 software set latches", mod_rst, 1);
         repeat (j) tick();
         ok = (j >= W);
         rd_ctrl(v);
         chk("R3 ready after software set", v, ctrl_exp(ok, 1));
         wr(0, 16'h0000);
         chk(ok ? "R5 clear after sw set" : "R4 early clear after sw set", mod_rst, !ok);
      end

      // R3: set while already latched restarts the timer
      hw_reset();
      repeat (W + SS) tick();
      rd_ctrl(v);
      chk("R2 ready before restart", v, ctrl_exp(1, 1));
      wr(0, 16'h0001);
      rd_ctrl(v);
      chk("R3 restart drops ready", v, ctrl_exp(0, 1));
      repeat (W - 1) tick();
      wr(0, 16'h0000);
      chk("R4 clear one edge early", mod_rst, 1);
      wr(0, 16'h0000);
      chk("R5 clear on ready edge", mod_rst, 0);

      // R6 R7: gating sweep over all word addresses in both states
      for (int s = 0; s < 2; s++) begin
         bit lk;
         lk = (s == 0);
         if (lk) wr(0, 16'h0001);
         for (int a = 1; a < 128; a++) begin
            host_addr  = AW'(a * 2 + (a % 2));
            down_rdata = {a[7:0], ~a[7:0]};
            host_wr    = 1'b1;
            host_rd    = 1'b1;
            #0.1;
            chk(lk ? "R6 write blocked" : "R7 write passes", down_wr_en, !lk);
            chk(lk ? "R6 read blocked" : "R7 read passes", down_rd_en, !lk);
            chk(lk ? "R6 read data zero" : "R7 read data", host_rdata,
                lk ? 32'h0 : {16'h0, a[7:0], ~a[7:0]});
            host_wr = 1'b0;
            host_rd = 1'b0;
            #0.1;
         end
         tick();
         chk(lk ? "R6 bit unchanged by blocked writes" : "R9 open after sweep", mod_rst, lk);
         if (lk) begin
            repeat (W) tick();
            wr(0, 16'h0000);
            chk("R5 clear after locked sweep", mod_rst, 0);
         end
      end

      // R8: control register decode ignores address bit 0, no downstream strobes
      host_addr = 8'h01;
      host_rd   = 1'b1;
      #0.2;
      chk("R8 ctrl read at odd byte", host_rdata, ctrl_exp(1, 0));
      chk("R8 ctrl read no strobe", down_rd_en, 0);
      host_rd = 1'b0;
      host_addr = 8'h00;
      host_wdata = 16'h0000;
      host_wr = 1'b1;
      #0.2;
      chk("R8 ctrl write no strobe", down_wr_en, 0);
      tick();
      host_wr = 1'b0;
      wr(8'h01, 16'hFFFE);
      chk("R8 upper bits ignored, bit0 zero clears nothing", mod_rst, 0);

      // R1: pin assertion acts without a clock edge
      #1;
      rst_pin_n = 1'b0;
      #0.3;
      chk("R1 async set", mod_rst, 1);
      rd_ctrl(v);
      chk("R1 ready cleared by pin", v, ctrl_exp(0, 1));
      tick();
      rst_pin_n = 1'b1;
      repeat (W + SS) tick();
      wr(0, 16'h0000);
      chk("R5 final clear", mod_rst, 0);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule